// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register transfer command into a stream of single-word memory requests. A command carries a base address, a 16-bit register selection mask, a two-bit addressing mode, a direction flag (load or store) and a flag that asks for the updated base value. The sequencer walks the selected registers in ascending register number. It presents one request per cycle on a valid/ready port, with the word address and the register index attached.

The register mask is laid out against memory so that the lowest-numbered selected register always sits at the lowest address. The four modes only move the window: it can run upward or downward from the base, and the base can be included in it or skipped. One cycle after the final request is accepted, a single-cycle completion pulse appears. If the command asked for it, the new base value comes with the pulse. A command with no registers selected issues no requests and completes at once with the base unchanged. A new command can be taken in the same cycle as the completion pulse of the previous one, so commands can run back to back.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset the block is idle: `start_ready` is 1 and `req_valid`, `done` and `wb_valid` are 0.
- R2: `start_mode` bit 1 selects the direction (1 = upward, 0 = downward) and bit 0 selects whether the base is skipped (1 = skip). With N selected registers, the first request address is: base for mode 2'b10, base+4 for 2'b11, base−4N+4 for 2'b00, and base−4N for 2'b01.
- R3: Successive requests of one command carry addresses that rise by 4 each time. They carry the selected register indices in strictly ascending order, so the lowest-numbered register gets the lowest address.
- R4: While `req_valid` is 1 and `req_ready` is 0, the request stays valid and its address and register index do not change.
- R5: `req_write` is 1 for a store command (`start_load` = 0) and 0 for a load. `req_last` is 1 on the final request of a command only.
- R6: `done` is 1 for exactly one cycle, in the cycle after the final request handshake, and `req_valid` is 0 in that cycle.
- R7: `wb_valid` is 1 together with `done` exactly when the command asked for the updated base. `wb_addr` then equals base+4N for the upward modes and base−4N for the downward modes.
- R8: An all-zero register mask produces no request. `done` comes in the cycle after the command is taken, and `wb_addr` equals the unchanged base.
- R9: A command is taken only when `start_ready` is 1, which holds when idle and during the `done` cycle. A command offered while requests are in progress is ignored and does not disturb the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Command can be taken this cycle |
| start_base | input | 32 | Base address of the command |
| start_mask | input | 16 | Register selection mask, bit i selects register i |
| start_mode | input | 2 | Addressing mode (see R2) |
| start_load | input | 1 | 1 = load, 0 = store |
| start_wb | input | 1 | Request the updated base value |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory port accepts the request |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_write | output | 1 | Request is a store |
| req_last | output | 1 | Final request of the command |
| done | output | 1 | Single-cycle completion pulse |
| wb_valid | output | 1 | Updated base is presented |
| wb_addr | output | 32 | Updated base value |

## Verification
Two functions can land in the same cycle: the completion pulse of one command and the capture of the next. The bench provokes this by chaining commands, offering the next command in the very cycle where `done` is expected. This includes chains of empty-mask commands, which give completion pulses in consecutive cycles. The bench then judges that the pulse and its writeback value belong to the old command, and that the first request of the new command shows up in the following cycle with its own address. Random backpressure and stray commands offered during a running sequence surround these cases.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
   // bit 1: direction (1 = upward), bit 0: skip the base word
   typedef enum logic [1:0] {
      MODE_DN_POST = 2'b00,
      MODE_DN_PRE  = 2'b01,
      MODE_UP_POST = 2'b10,
      MODE_UP_PRE  = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_DONE = 2'b10
   } seq_state_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
   parameter int N       = 16,
   parameter int IW      = $clog2(N),
   parameter bit ISOLATE = 1'b1
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          single
);
   // at most one bit set
   assign single = ((vec & (vec - N'(1))) == '0);

   generate
      if (ISOLATE) begin : g_isolate
         logic [N-1:0] onehot;
         assign onehot = vec & (~vec + N'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (onehot[i]) idx = idx | IW'(i);
            end
         end
      end else begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/blkxfer_addrgen.sv
module blkxfer_addrgen
   import blkxfer_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 5,
   parameter int SH = 2
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] cnt,
   input  xfer_mode_e    mode,
   output logic [AW-1:0] first_addr,
   output logic [AW-1:0] final_addr
);
   logic [AW-1:0] span;
   logic [AW-1:0] step;

   assign span = AW'(cnt) << SH;
   assign step = AW'(1) << SH;

   always_comb begin
      case (mode)
         MODE_UP_POST: first_addr = base;
         MODE_UP_PRE:  first_addr = base + step;
         MODE_DN_POST: first_addr = base - span + step;
         default:      first_addr = base - span;
      endcase
      if (mode == MODE_UP_POST || mode == MODE_UP_PRE) final_addr = base + span;
      else                                             final_addr = base - span;
   end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int AW          = 32,
   parameter int NREGS       = 16,
   parameter int WORD_BYTES  = 4,
   parameter bit ISOLATE_LOW = 1'b1,
   localparam int IW         = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   output logic             start_ready,
   input  logic [AW-1:0]    start_base,
   input  logic [NREGS-1:0] start_mask,
   input  logic [1:0]       start_mode,
   input  logic             start_load,
   input  logic             start_wb,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [AW-1:0]    req_addr,
   output logic [IW-1:0]    req_reg,
   output logic             req_write,
   output logic             req_last,
   output logic             done,
   output logic             wb_valid,
   output logic [AW-1:0]    wb_addr
);
   localparam int CW = $clog2(NREGS + 1);
   localparam int SH = $clog2(WORD_BYTES);

   generate
      if (NREGS < 2) begin : g_bad_nregs
         $error("blkxfer_seq: NREGS must be at least 2");
      end
      if (WORD_BYTES != (1 << SH)) begin : g_bad_word
         $error("blkxfer_seq: WORD_BYTES must be a power of two");
      end
      if (AW < SH + CW + 1) begin : g_bad_aw
         $error("blkxfer_seq: AW too narrow for the transfer span");
      end
   endgenerate

   seq_state_e       st_q;
   logic [NREGS-1:0] mask_q;
   logic [AW-1:0]    addr_q;
   logic [AW-1:0]    wbaddr_q;
   logic             load_q;
   logic             wb_q;

   logic [CW-1:0]    sel_cnt;
   logic [AW-1:0]    first_a;
   logic [AW-1:0]    final_a;
   logic [IW-1:0]    cur_idx;
   logic             cur_single;
   logic             take;
   logic             fire;

   blkxfer_popcnt #(.N(NREGS), .CW(CW)) u_cnt (
      .vec (start_mask),
      .cnt (sel_cnt)
   );

   blkxfer_addrgen #(.AW(AW), .CW(CW), .SH(SH)) u_addr (
      .base       (start_base),
      .cnt        (sel_cnt),
      .mode       (xfer_mode_e'(start_mode)),
      .first_addr (first_a),
      .final_addr (final_a)
   );

   blkxfer_lowbit #(.N(NREGS), .IW(IW), .ISOLATE(ISOLATE_LOW)) u_low (
      .vec    (mask_q),
      .idx    (cur_idx),
      .single (cur_single)
   );

   assign start_ready = (st_q != ST_RUN);
   assign take        = start_valid && start_ready;
   assign req_valid   = (st_q == ST_RUN);
   assign fire        = req_valid && req_ready;
   assign req_addr    = addr_q;
   assign req_reg     = cur_idx;
   assign req_write   = !load_q;
   assign req_last    = req_valid && cur_single;
   assign done        = (st_q == ST_DONE);
   assign wb_valid    = done && wb_q;
   assign wb_addr     = wbaddr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         mask_q   <= '0;
         addr_q   <= '0;
         wbaddr_q <= '0;
         load_q   <= 1'b0;
         wb_q     <= 1'b0;
      end else if (take) begin
         mask_q   <= start_mask;
         addr_q   <= first_a;
         wbaddr_q <= final_a;
         load_q   <= start_load;
         wb_q     <= start_wb;
         st_q     <= (|start_mask) ? ST_RUN : ST_DONE;
      end else if (fire) begin
         mask_q <= mask_q & (mask_q - NREGS'(1));
         addr_q <= addr_q + AW'(WORD_BYTES);
         if (cur_single) st_q <= ST_DONE;
      end else if (st_q == ST_DONE) begin
         st_q <= ST_IDLE;
      end
   end
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
   parameter int AW = 32,
   parameter int IW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_ready,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic [IW-1:0] req_reg,
   input logic          req_last,
   input logic          done,
   input logic          wb_valid
);
   p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (start_ready && !req_valid && !done && !wb_valid));

   p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_last) |=>
         (req_valid && req_addr == $past(req_addr) + AW'(4) && req_reg > $past(req_reg)));

   p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg)));

   p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_last) |=> (done && !req_valid));

   p_wb_only_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);

   p_no_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !start_ready);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW), .IW(IW)) u_chk (.*);

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;
   import blkxfer_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0;
   logic        start_ready;
   logic [31:0] start_base = '0;
   logic [15:0] start_mask = '0;
   logic [1:0]  start_mode = '0;
   logic        start_load = 1'b0;
   logic        start_wb = 1'b0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr;
   logic [3:0]  req_reg;
   logic        req_write;
   logic        req_last;
   logic        done;
   logic        wb_valid;
   logic [31:0] wb_addr;

   int checks = 0;
   int errors = 0;

   logic [31:0] op_base, nxt_base;
   logic [15:0] op_mask, nxt_mask;
   logic [1:0]  op_mode, nxt_mode;
   logic        op_ld, nxt_ld, op_wb, nxt_wb;

   always #5 clk = ~clk;

   blkxfer_seq u_blkxfer_seq (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int popc(input logic [15:0] m);
      int n = 0;
      for (int i = 0; i < 16; i++) n += int'(m[i]);
      return n;
   endfunction

   function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
      logic [31:0] sp = 32'(popc(m)) * 32'd4;
      case (md)
         2'b10:   return b;
         2'b11:   return b + 32'd4;
         2'b00:   return b - sp + 32'd4;
         default: return b - sp;
      endcase
   endfunction

   function automatic logic [31:0] exp_final(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
      logic [31:0] sp = 32'(popc(m)) * 32'd4;
      return md[1] ? b + sp : b - sp;
   endfunction

   function automatic logic [3:0] lowest(input logic [15:0] m);
      for (int i = 0; i < 16; i++) if (m[i]) return 4'(i);
      return 4'd0;
   endfunction

   task automatic issue(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                        input logic ld, input logic wb);
      start_valid = 1'b1;
      start_base = b; start_mask = m; start_mode = md; start_load = ld; start_wb = wb;
      op_base = b; op_mask = m; op_mode = md; op_ld = ld; op_wb = wb;
   endtask

   // called at the negedge where a command is being offered
   task automatic walk(input bit chain);
      logic [15:0] rem = op_mask;
      logic [31:0] a = exp_first(op_base, op_mask, op_mode);
      bit first = 1'b1;
      bit garb = 1'b0;
      int guard = 0;
      @(posedge clk); @(negedge clk);
      start_valid = 1'b0;
      while (rem != 16'd0 && guard < 400) begin
         string tg;
         bit rdy;
         guard++;
         tg = garb ? "R9" : (first ? "R2" : "R3");
         chk(tg, "req_valid", 32'(req_valid), 32'd1);
         chk(tg, "req_addr", req_addr, a);
         chk("R3", "req_reg", 32'(req_reg), 32'(lowest(rem)));
         chk("R5", "req_write", 32'(req_write), 32'(!op_ld));
         chk("R5", "req_last", 32'(req_last), 32'((rem & (rem - 16'd1)) == 16'd0));
         chk("R9", "start_ready busy", 32'(start_ready), 32'd0);
         chk("R6", "done while busy", 32'(done), 32'd0);
         rdy = ($urandom % 4) != 0;
         req_ready = rdy;
         garb = ($urandom % 3) == 0;
         if (garb) begin
            start_valid = 1'b1;
            start_base = $urandom; start_mask = 16'($urandom);
            start_mode = 2'($urandom); start_load = 1'($urandom); start_wb = 1'($urandom);
         end else start_valid = 1'b0;
         @(posedge clk); @(negedge clk);
         if (rdy) begin
            rem = rem & (rem - 16'd1);
            a = a + 32'd4;
            first = 1'b0;
         end else if (!first) begin
            tg = "R4";
         end
      end
      if (guard >= 400) chk("R6", "sequence length", 32'(guard), 32'(popc(op_mask)));
      begin
         string dt = (op_mask == 16'd0) ? "R8" : "R6";
         chk(dt, "done", 32'(done), 32'd1);
         chk(dt, "req_valid in done", 32'(req_valid), 32'd0);
         chk("R7", "wb_valid", 32'(wb_valid), 32'(op_wb));
         if (op_wb) chk((op_mask == 16'd0) ? "R8" : "R7", "wb_addr", wb_addr,
                        exp_final(op_base, op_mask, op_mode));
         chk("R9", "start_ready in done", 32'(start_ready), 32'd1);
      end
      if (chain) begin
         issue(nxt_base, nxt_mask, nxt_mode, nxt_ld, nxt_wb);
      end else begin
         start_valid = 1'b0;
         req_ready = 1'b0;
         @(posedge clk); @(negedge clk);
         chk("R6", "done pulse width", 32'(done), 32'd0);
         chk("R6", "idle after done", 32'(start_ready), 32'd1);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "start_ready", 32'(start_ready), 32'd1);
      chk("R1", "req_valid", 32'(req_valid), 32'd0);
      chk("R1", "done", 32'(done), 32'd0);
      chk("R1", "wb_valid", 32'(wb_valid), 32'd0);

      // empty list
      issue(32'h0000_1000, 16'h0000, 2'b01, 1'b0, 1'b1); walk(1'b0);
      // every mode on the same list
      for (int md = 0; md < 4; md++) begin
         issue(32'h0000_2000, 16'h8421, 2'(md), 1'b1, 1'b1); walk(1'b0);
      end
      issue(32'h0000_0040, 16'hFFFF, 2'b11, 1'b1, 1'b1); walk(1'b0);
      issue(32'h0000_0000, 16'hFFFF, 2'b01, 1'b0, 1'b1); walk(1'b0);
      issue(32'h0000_3000, 16'h8000, 2'b00, 1'b0, 1'b0); walk(1'b0);
      issue(32'h0000_3000, 16'h0001, 2'b10, 1'b1, 1'b1); walk(1'b0);

      // back-to-back: next command taken in the done cycle
      nxt_base = 32'h0000_4000; nxt_mask = 16'h0000; nxt_mode = 2'b11; nxt_ld = 1'b0; nxt_wb = 1'b1;
      issue(32'h0000_5000, 16'h0010, 2'b10, 1'b1, 1'b1); walk(1'b1);
      nxt_base = 32'h0000_6000; nxt_mask = 16'h0000; nxt_mode = 2'b00; nxt_ld = 1'b1; nxt_wb = 1'b1;
      walk(1'b1);
      nxt_base = 32'h0000_7000; nxt_mask = 16'h0C03; nxt_mode = 2'b01; nxt_ld = 1'b0; nxt_wb = 1'b1;
      walk(1'b1);
      walk(1'b0);

      // random commands
      for (int k = 0; k < 80; k++) begin
         logic [15:0] m = 16'($urandom);
         if (k % 5 == 0) m = m & 16'h0111;
         issue($urandom & 32'hFFFF_FFFC, m, 2'($urandom), 1'($urandom), 1'($urandom));
         walk(1'b0);
      end

      summary();
      $finish;
   end
endmodule